// File: doc/BRIEF.md
# Hardware breakpoint control unit

This block watches a processor's instruction-fetch stream and data-access stream and raises a debug exception when an access lands on one of four programmed breakpoints. Each breakpoint slot has an address register and, in a shared control register, a two-bit condition code, a two-bit length code and a pair of enables. One enable is cleared when the task changes. The other one survives a task change. Every slot whose condition is met is logged in a sticky status register, whether or not that slot is enabled. A debug exception is signalled only when a matching slot has at least one of its enables set.

Software reaches the registers through an addressed request port. The port uses a valid/ready pair, but the block never applies back-pressure: `reg_ready` is high at all times out of reset, so every request with `reg_valid` high is taken on the clock edge that samples it. A read answers one cycle later on `reg_rvalid`/`reg_rdata`. The response has no ready and cannot be stalled. The fetch and data streams are valid-qualified observations with no ready, because the block only watches them.

A protection mode can be turned on. While it is on, any register access is refused and traps instead, and the status register records the cause. A handler-entry strobe turns the protection off again so that the debug handler can use the registers.

Top module: `hwbp_unit`

## Requirements
- R1: After reset, all four slot address registers, the status register and the control register read as zero, and `dbg_exc` is low.
- R2: Register addresses 0 to 3 are the slot address registers, 4 is status and 5 is control. A write takes effect on the accepting edge. A read returns the value with `reg_rvalid` high in the following cycle. Addresses 6 and 7 read as zero, and writes to them are dropped. `reg_ready` is always high.
- R3: Control bit 2n is the local enable of slot n and bit 2n+1 is its global enable. A matched slot raises `dbg_exc` if either of its two enables is set, and a matched slot with neither enable set does not.
- R4: Control bits 17+4n:16+4n are the condition of slot n. 00 matches a fetch whose full address equals the slot address. 01 matches data writes only. 11 matches data reads and data writes. 10 never matches.
- R5: Control bits 19+4n:18+4n are the length of slot n. 00, 01, 10 and 11 select 1, 2, 8 and 4 bytes. A data access matches when its address and the slot address agree once the low 0, 1, 3 or 2 bits are ignored.
- R6: Status bits 3:0 are set for every slot whose condition matched, whether or not that slot is enabled. Status bits are only cleared by a software write to address 4, which stores bits 13 and 3:0.
- R7: A `task_switch` pulse clears every local enable and leaves the global enables unchanged.
- R8: Control bits 8 and 9 are stored and read back, and they have no effect on matching or on `dbg_exc`.
- R9: While control bit 13 is set, any register access is refused. The access changes no register and gives no read response, `dbg_exc` is raised, and status bit 13 is set on the same edge.
- R10: A `handler_entry` pulse clears control bit 13. When a strobe and a control write fall in the same cycle, the strobe's clearing is applied on top of the written value.
- R11: `dbg_exc` is a registered pulse that is high for the one cycle after the edge that sampled the causing access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register request valid |
| reg_ready | output | 1 | Register request ready (always high) |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read response valid, one cycle after an accepted read |
| reg_rdata | output | 32 | Read response data |
| fetch_valid | input | 1 | Instruction fetch observed this cycle |
| fetch_addr | input | ADDR_W | Fetch address |
| data_valid | input | 1 | Data access observed this cycle |
| data_write | input | 1 | 1 = data write, 0 = data read |
| data_addr | input | ADDR_W | Data access address |
| task_switch | input | 1 | Task-switch strobe |
| handler_entry | input | 1 | Debug handler entry strobe |
| dbg_exc | output | 1 | Debug exception pulse |

## Verification
Every result of this block is due exactly one clock edge after the edge that samples its stimulus. This covers the exception pulse, the status bits, register updates, enable clearing by the strobes, and the read response with its data. The bench drives each stimulus on a falling edge and holds it for one rising edge. It removes the stimulus on the next falling edge and samples the outputs there, so each check sees the effect of that one rising edge only. A further check one cycle later confirms that the exception pulse has dropped again.

// File: rtl/hwbp_pkg.sv
package hwbp_pkg;
  localparam int NSLOT  = 4;
  localparam int REG_W  = 32;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_STAT = 3'd4;
  localparam logic [REG_AW-1:0] RA_CTRL = 3'd5;

  localparam int CTL_PROT    = 13;
  localparam int STS_PROT    = 13;
  localparam int FIELD_BASE  = 16;
  localparam int FIELD_PITCH = 4;

  localparam logic [REG_W-1:0] CTRL_WMASK = 32'hFFFF_23FF;
  localparam logic [REG_W-1:0] STAT_WMASK = 32'h0000_200F;

  typedef enum logic [1:0] {
    COND_EXEC = 2'b00,
    COND_WR   = 2'b01,
    COND_NONE = 2'b10,
    COND_RW   = 2'b11
  } cond_e;

  function automatic logic [REG_W-1:0] local_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NSLOT; i++) m[2*i] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] global_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NSLOT; i++) m[2*i+1] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/hwbp_slot.sv
module hwbp_slot
  import hwbp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic [1:0]        cond,
  input  logic [1:0]        len,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              data_valid,
  input  logic              data_write,
  input  logic [ADDR_W-1:0] data_addr,
  output logic              hit
);
  logic [ADDR_W-1:0] low_bits;
  logic [ADDR_W-1:0] keep;
  logic              fetch_hit;
  logic              data_hit;
  logic              same_window;
  cond_e             kind;

  always_comb begin
    kind = cond_e'(cond);
    unique case (len)
      2'b00:   low_bits = '0;
      2'b01:   low_bits = ADDR_W'(1);
      2'b10:   low_bits = ADDR_W'(7);
      default: low_bits = ADDR_W'(3);
    endcase
    keep        = ~low_bits;
    same_window = (data_addr & keep) == (bp_addr & keep);
    fetch_hit   = fetch_valid && (kind == COND_EXEC) && (fetch_addr == bp_addr);
    data_hit    = data_valid && same_window &&
                  (((kind == COND_WR) && data_write) || (kind == COND_RW));
    hit         = fetch_hit || data_hit;
  end
endmodule

// File: rtl/hwbp_regs.sv
module hwbp_regs
  import hwbp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_valid,
  input  logic                         reg_we,
  input  logic [REG_AW-1:0]            reg_addr,
  input  logic [REG_W-1:0]             reg_wdata,
  input  logic                         task_switch,
  input  logic                         handler_entry,
  input  logic [NSLOT-1:0]             slot_hit,
  output logic [NSLOT-1:0][ADDR_W-1:0] bp_addr,
  output logic [REG_W-1:0]             ctrl_q,
  output logic [REG_W-1:0]             status_q,
  output logic                         prot_trap,
  output logic                         reg_rvalid,
  output logic [REG_W-1:0]             reg_rdata
);
  localparam logic [REG_W-1:0] LMASK = local_mask();

  logic             wr_ok;
  logic             rd_ok;
  logic [REG_W-1:0] ctrl_n;
  logic [REG_W-1:0] status_n;
  logic [REG_W-1:0] rd_mux;

  always_comb begin
    prot_trap = reg_valid && ctrl_q[CTL_PROT];
    wr_ok     = reg_valid && reg_we && !ctrl_q[CTL_PROT];
    rd_ok     = reg_valid && !reg_we && !ctrl_q[CTL_PROT];

    ctrl_n = ctrl_q;
    if (wr_ok && reg_addr == RA_CTRL) ctrl_n = reg_wdata & CTRL_WMASK;
    if (task_switch) ctrl_n = ctrl_n & ~LMASK;
    if (handler_entry) ctrl_n[CTL_PROT] = 1'b0;

    status_n = status_q;
    if (wr_ok && reg_addr == RA_STAT) status_n = reg_wdata & STAT_WMASK;
    status_n[NSLOT-1:0] = status_n[NSLOT-1:0] | slot_hit;
    if (prot_trap) status_n[STS_PROT] = 1'b1;

    rd_mux = '0;
    for (int i = 0; i < NSLOT; i++)
      if (reg_addr == REG_AW'(i)) rd_mux = REG_W'(bp_addr[i]);
    if (reg_addr == RA_STAT) rd_mux = status_q;
    if (reg_addr == RA_CTRL) rd_mux = ctrl_q;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_addr
    always_ff @(posedge clk) begin
      if (!rst_n) bp_addr[g] <= '0;
      else if (wr_ok && reg_addr == REG_AW'(g)) bp_addr[g] <= reg_wdata[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      status_q   <= '0;
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      ctrl_q     <= ctrl_n;
      status_q   <= status_n;
      reg_rvalid <= rd_ok;
      if (rd_ok) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/hwbp_qual.sv
module hwbp_qual
  import hwbp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] slot_hit,
  input  logic [NSLOT-1:0] lcl_en,
  input  logic [NSLOT-1:0] gbl_en,
  input  logic             prot_trap,
  output logic             dbg_exc
);
  logic raise;

  always_comb raise = (|(slot_hit & (lcl_en | gbl_en))) || prot_trap;

  always_ff @(posedge clk) begin
    if (!rst_n) dbg_exc <= 1'b0;
    else        dbg_exc <= raise;
  end
endmodule

// File: rtl/hwbp_unit.sv
module hwbp_unit
  import hwbp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  output logic              reg_ready,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              reg_rvalid,
  output logic [31:0]       reg_rdata,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              data_valid,
  input  logic              data_write,
  input  logic [ADDR_W-1:0] data_addr,
  input  logic              task_switch,
  input  logic              handler_entry,
  output logic              dbg_exc
);
  logic [NSLOT-1:0][ADDR_W-1:0] bp_addr;
  logic [REG_W-1:0]             ctrl_q;
  logic [REG_W-1:0]             status_q;
  logic [NSLOT-1:0]             slot_hit;
  logic [NSLOT-1:0]             lcl_en;
  logic [NSLOT-1:0]             gbl_en;
  logic                         prot_trap;

  assign reg_ready = 1'b1;

  hwbp_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_valid     (reg_valid),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .task_switch   (task_switch),
    .handler_entry (handler_entry),
    .slot_hit      (slot_hit),
    .bp_addr       (bp_addr),
    .ctrl_q        (ctrl_q),
    .status_q      (status_q),
    .prot_trap     (prot_trap),
    .reg_rvalid    (reg_rvalid),
    .reg_rdata     (reg_rdata)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign lcl_en[g] = ctrl_q[2*g];
    assign gbl_en[g] = ctrl_q[2*g+1];

    hwbp_slot #(.ADDR_W(ADDR_W)) u_slot (
      .bp_addr     (bp_addr[g]),
      .cond        (ctrl_q[FIELD_BASE + FIELD_PITCH*g +: 2]),
      .len         (ctrl_q[FIELD_BASE + FIELD_PITCH*g + 2 +: 2]),
      .fetch_valid (fetch_valid),
      .fetch_addr  (fetch_addr),
      .data_valid  (data_valid),
      .data_write  (data_write),
      .data_addr   (data_addr),
      .hit         (slot_hit[g])
    );
  end

  hwbp_qual u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_hit  (slot_hit),
    .lcl_en    (lcl_en),
    .gbl_en    (gbl_en),
    .prot_trap (prot_trap),
    .dbg_exc   (dbg_exc)
  );
endmodule

// File: rtl/hwbp_unit_chk.sv
module hwbp_unit_chk
  import hwbp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_valid,
  input logic             reg_we,
  input logic [2:0]       reg_addr,
  input logic             reg_rvalid,
  input logic             task_switch,
  input logic             handler_entry,
  input logic             dbg_exc,
  input logic [31:0]      ctrl_q,
  input logic [31:0]      status_q,
  input logic [NSLOT-1:0] slot_hit
);
  localparam logic [31:0] LM = local_mask();
  localparam logic [31:0] GM = global_mask();

  logic [NSLOT-1:0] en_any;
  logic             ctl_wr;
  logic             sts_wr;

  always_comb begin
    for (int i = 0; i < NSLOT; i++) en_any[i] = ctrl_q[2*i] | ctrl_q[2*i+1];
    ctl_wr = reg_valid && reg_we && reg_addr == RA_CTRL;
    sts_wr = reg_valid && reg_we && reg_addr == RA_STAT && !ctrl_q[CTL_PROT];
  end

  AST_LOCAL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    task_switch |=> (ctrl_q & LM) == '0); // R7

  AST_GLOBAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    task_switch && !ctl_wr |=> (ctrl_q & GM) == ($past(ctrl_q) & GM)); // R7

  AST_PROT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    handler_entry |=> !ctrl_q[CTL_PROT]); // R10

  AST_PROT_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && ctrl_q[CTL_PROT] |=> dbg_exc && status_q[STS_PROT] && !reg_rvalid); // R9

  AST_PROT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && ctrl_q[CTL_PROT] && !task_switch && !handler_entry |=> $stable(ctrl_q)); // R9

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_wr |=> (status_q & $past(status_q)) == $past(status_q)); // R6

  AST_HIT_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
    |slot_hit |=> (status_q[NSLOT-1:0] & $past(slot_hit)) == $past(slot_hit)); // R6

  AST_EXC_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    |(slot_hit & en_any) |=> dbg_exc); // R3
endmodule

bind hwbp_unit hwbp_unit_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_valid     (reg_valid),
  .reg_we        (reg_we),
  .reg_addr      (reg_addr),
  .reg_rvalid    (reg_rvalid),
  .task_switch   (task_switch),
  .handler_entry (handler_entry),
  .dbg_exc       (dbg_exc),
  .ctrl_q        (ctrl_q),
  .status_q      (status_q),
  .slot_hit      (slot_hit)
);

// File: tb/hwbp_unit_tb_top.sv
`timescale 1ns/1ps
module hwbp_unit_tb_top;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_FE = 3'd2, OP_DR = 3'd3,
                         OP_DW = 3'd4, OP_TS = 3'd5, OP_HE = 3'd6;

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] d;
    logic        exc;
    logic        rv;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 39;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  OP_WR, 32'h0,    32'h1000,     1'b0, 1'b0, 32'h0},         // R2 slot0 addr
    '{4'd2,  OP_RD, 32'h0,    32'h0,        1'b0, 1'b1, 32'h1000},      // R2 readback
    '{4'd3,  OP_WR, 32'h5,    32'h2,        1'b0, 1'b0, 32'h0},         // R3 global enable slot0
    '{4'd4,  OP_FE, 32'h1000, 32'h0,        1'b1, 1'b0, 32'h0},         // R4 fetch hit
    '{4'd4,  OP_FE, 32'h1004, 32'h0,        1'b0, 1'b0, 32'h0},         // R4 fetch miss
    '{4'd6,  OP_RD, 32'h4,    32'h0,        1'b0, 1'b1, 32'h1},         // R6 B0 logged
    '{4'd6,  OP_WR, 32'h4,    32'h0,        1'b0, 1'b0, 32'h0},         // R6 clear status
    '{4'd6,  OP_RD, 32'h4,    32'h0,        1'b0, 1'b1, 32'h0},         // R6
    '{4'd2,  OP_WR, 32'h1,    32'h2000,     1'b0, 1'b0, 32'h0},         // R2 slot1 addr
    '{4'd5,  OP_WR, 32'h5,    32'h00D00006, 1'b0, 1'b0, 32'h0},         // R5 slot1 write 4B L1
    '{4'd5,  OP_DW, 32'h2003, 32'h0,        1'b1, 1'b0, 32'h0},         // R5 inside 4B window
    '{4'd4,  OP_DR, 32'h2000, 32'h0,        1'b0, 1'b0, 32'h0},         // R4 write-only ignores read
    '{4'd5,  OP_DW, 32'h2004, 32'h0,        1'b0, 1'b0, 32'h0},         // R5 outside window
    '{4'd7,  OP_TS, 32'h0,    32'h0,        1'b0, 1'b0, 32'h0},         // R7 task switch
    '{4'd7,  OP_RD, 32'h5,    32'h0,        1'b0, 1'b1, 32'h00D00002},  // R7 L1 cleared, G0 kept
    '{4'd7,  OP_FE, 32'h1000, 32'h0,        1'b1, 1'b0, 32'h0},         // R7 global still fires
    '{4'd3,  OP_DW, 32'h2001, 32'h0,        1'b0, 1'b0, 32'h0},         // R3 match without enable
    '{4'd6,  OP_RD, 32'h4,    32'h0,        1'b0, 1'b1, 32'h3},         // R6 B1 set though disabled
    '{4'd2,  OP_WR, 32'h2,    32'h3000,     1'b0, 1'b0, 32'h0},         // R2 slot2 addr
    '{4'd8,  OP_WR, 32'h5,    32'h0B000322, 1'b0, 1'b0, 32'h0},         // R8 slot2 rw 8B, bits 8/9
    '{4'd5,  OP_DR, 32'h3007, 32'h0,        1'b1, 1'b0, 32'h0},         // R5 8B window read hit
    '{4'd5,  OP_DR, 32'h3008, 32'h0,        1'b0, 1'b0, 32'h0},         // R5 8B window edge
    '{4'd8,  OP_RD, 32'h5,    32'h0,        1'b0, 1'b1, 32'h0B000322},  // R8 bits read back
    '{4'd2,  OP_WR, 32'h3,    32'h4000,     1'b0, 1'b0, 32'h0},         // R2 slot3 addr
    '{4'd4,  OP_WR, 32'h5,    32'h2B0003A2, 1'b0, 1'b0, 32'h0},         // R4 slot3 code 10
    '{4'd4,  OP_DW, 32'h4000, 32'h0,        1'b0, 1'b0, 32'h0},         // R4 code 10 never
    '{4'd4,  OP_FE, 32'h4000, 32'h0,        1'b0, 1'b0, 32'h0},         // R4 code 10 never
    '{4'd5,  OP_WR, 32'h5,    32'h2B5003A6, 1'b0, 1'b0, 32'h0},         // R5 slot1 write 2B L1
    '{4'd5,  OP_DW, 32'h2001, 32'h0,        1'b1, 1'b0, 32'h0},         // R5 2B hit
    '{4'd5,  OP_DW, 32'h2002, 32'h0,        1'b0, 1'b0, 32'h0},         // R5 2B miss
    '{4'd2,  OP_WR, 32'h7,    32'hFFFFFFFF, 1'b0, 1'b0, 32'h0},         // R2 undefined addr
    '{4'd2,  OP_RD, 32'h7,    32'h0,        1'b0, 1'b1, 32'h0},         // R2 reads zero
    '{4'd9,  OP_WR, 32'h5,    32'h2B5023A6, 1'b0, 1'b0, 32'h0},         // R9 set protection
    '{4'd9,  OP_RD, 32'h5,    32'h0,        1'b1, 1'b0, 32'h0},         // R9 read traps
    '{4'd9,  OP_WR, 32'h0,    32'hDEAD,     1'b1, 1'b0, 32'h0},         // R9 write traps
    '{4'd10, OP_HE, 32'h0,    32'h0,        1'b0, 1'b0, 32'h0},         // R10 handler entry
    '{4'd10, OP_RD, 32'h5,    32'h0,        1'b0, 1'b1, 32'h2B5003A6},  // R10 protection off
    '{4'd9,  OP_RD, 32'h0,    32'h0,        1'b0, 1'b1, 32'h1000},      // R9 slot0 untouched
    '{4'd9,  OP_RD, 32'h4,    32'h0,        1'b0, 1'b1, 32'h2007}       // R9 BD set, R6 sticky
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        fetch_valid = 1'b0, data_valid = 1'b0, data_write = 1'b0;
  logic [31:0] fetch_addr = '0, data_addr = '0;
  logic        task_switch = 1'b0, handler_entry = 1'b0;
  logic        reg_ready, reg_rvalid, dbg_exc;
  logic [31:0] reg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hwbp_unit #(.ADDR_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .data_valid(data_valid), .data_write(data_write), .data_addr(data_addr),
    .task_switch(task_switch), .handler_entry(handler_entry),
    .dbg_exc(dbg_exc)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    reg_valid = 0; reg_we = 0; fetch_valid = 0; data_valid = 0; data_write = 0;
    task_switch = 0; handler_entry = 0;
  endtask

  task automatic apply(input vec_t v, input int idx);
    string tag;
    tag = $sformatf("R%0d vec%0d", v.req, idx);
    @(negedge clk);
    case (v.op)
      OP_WR: begin reg_valid = 1; reg_we = 1; reg_addr = v.a[2:0]; reg_wdata = v.d; end
      OP_RD: begin reg_valid = 1; reg_we = 0; reg_addr = v.a[2:0]; end
      OP_FE: begin fetch_valid = 1; fetch_addr = v.a; end
      OP_DR: begin data_valid = 1; data_write = 0; data_addr = v.a; end
      OP_DW: begin data_valid = 1; data_write = 1; data_addr = v.a; end
      OP_TS: task_switch = 1;
      OP_HE: handler_entry = 1;
      default: ;
    endcase
    @(negedge clk);
    idle_inputs();
    check(dbg_exc === v.exc, {tag, " dbg_exc"}, 32'(dbg_exc), 32'(v.exc));
    if (v.op == OP_RD) begin
      check(reg_rvalid === v.rv, {tag, " rvalid"}, 32'(reg_rvalid), 32'(v.rv));
      if (v.rv) check(reg_rdata === v.exp, {tag, " rdata"}, reg_rdata, v.exp);
    end
  endtask

  task automatic read_zero(input logic [2:0] a);
    vec_t v;
    v = '{4'd1, OP_RD, 32'(a), 32'h0, 1'b0, 1'b1, 32'h0};
    apply(v, 100 + int'(a));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(dbg_exc === 1'b0 && reg_ready === 1'b1, "R1 reset outputs",
          {30'b0, reg_ready, dbg_exc}, 32'h2);
    for (int i = 0; i < NV; i++) apply(VECS[i], i);

    // R11: the pulse lasts one cycle only
    apply('{4'd11, OP_FE, 32'h1000, 32'h0, 1'b1, 1'b0, 32'h0}, 200);
    @(negedge clk);
    check(dbg_exc === 1'b0, "R11 pulse dropped", 32'(dbg_exc), 32'h0);

    // R1: reapply reset and confirm every register reads zero
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check(dbg_exc === 1'b0 && reg_rvalid === 1'b0, "R1 outputs after reset",
          {30'b0, reg_rvalid, dbg_exc}, 32'h0);
    for (int a = 0; a < 6; a++) read_zero(3'(a));
    // R1: control cleared, so a fetch at a former breakpoint does not trap
    apply('{4'd1, OP_FE, 32'h1000, 32'h0, 1'b0, 1'b0, 32'h0}, 300);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule